// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock waveform and the START, repeated START and STOP line conditions for the master side of an I2C controller. It works from a prescaler clock-enable tick. One configuration word carries two 3-bit codes: a low-time code and a high-time code. Together they set every bus interval. The low count governs the SCL low phase, the bus-free wait before a START and the setup before a repeated START. The high count governs the SCL high phase, the setup before a STOP and the hold after a START.

A byte engine above this block hands over one request at a time: START, repeated START, STOP or one data bit period. The block drives SCL and SDA only as open-drain pull-down enables. It watches the real SCL line through a synchronizer, so it follows a slave that stretches the clock and it falls into step with another master that pulls SCL low early. A one-cycle done pulse marks the end of each request. The block then holds the lines where that request left them until the next request arrives.

Top module: `i2c_scl_timing`

## Requirements
- R1: The configuration word holds the low code in bits 2:0 and the high code in bits 6:4. Every other bit reads as zero. The reset value is 0x77, and a write (cfg_we high) shows on cfg_rdata on the following cycle.
- R2: A code N gives a phase length of N+2 ticks. During a bit period, SCL is pulled low from the cycle after acceptance for exactly the low length.
- R3: SCL is sampled through a two-flop synchronizer. With a tick on every cycle and no other device on the bus, SCL stays released for the high length plus 3 cycles. Phase_done then rises in the same cycle that SCL is pulled low again.
- R4: Clock stretching. If another device holds SCL low beyond the low count, the block keeps waiting. The high count starts only after SCL is sampled high, so the released time after the line rises is still the high length plus 3 cycles.
- R5: High-phase cut. If SCL goes low during the high count, the block pulls SCL low and signals done 3 cycles after the line falls. If the count would have ended sooner, the count ends the phase instead.
- R6: START (req_op 0): both lines are released for the low length, which is the bus-free wait. SDA is then pulled while SCL stays released, for the high length. After that SCL is pulled and done is raised.
- R7: Repeated START (req_op 1): SDA is released and SCL is pulled for the low length. SCL is then released and waited for, the setup runs for the low length with SCL high, SDA is pulled for the high-length hold, and finally SCL is pulled and done is raised.
- R8: STOP (req_op 2): SDA and SCL are pulled for the low length. SCL is then released and waited for, the setup runs for the high length, and SDA is released together with done.
- R9: Bit period (req_op 3): SDA is pulled when req_bit is 0 and released when it is 1, from the cycle after acceptance until the next request.
- R10: phase_done lasts one cycle. req_ready is high only while idle. A request raised while busy is ignored, and after a bit period the lines stay unchanged with no further done.
- R11: A configuration write made while a phase is running leaves that phase's length unchanged. The next phase uses the new code.
- R12: Phase counters advance only on cycles with tick high, so a low phase spans exactly the low length in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled clock enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 START, 1 repeated START, 2 STOP, 3 bit period |
| req_bit | input | 1 | Data bit for a bit period |
| req_ready | output | 1 | Block idle, request will be taken |
| phase_done | output | 1 | One-cycle end-of-request pulse |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull | output | 1 | Pull SCL low when high |
| sda_pull | output | 1 | Pull SDA low when high |

## Verification
Within a single cycle, the high-phase counter can reach its last tick while the synchronized SCL shows that another master has pulled the line low. Both events end the phase, and only one done pulse may result. The bench provokes this by sweeping the cycle where an external low pulse starts across the whole high phase, including the points beside the count's natural end. For each position it judges the sample index of phase_done against the minimum of the pulse index plus 3 and the index of the natural end.

// File: rtl/i2c_scl_timing_pkg.sv
package i2c_scl_timing_pkg;
  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_STOP   = 2'd2,
    OP_BIT    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_BUF  = 3'd1,
    S_HOLD = 3'd2,
    S_LO   = 3'd3,
    S_WHI  = 3'd4,
    S_SU   = 3'd5,
    S_HI   = 3'd6
  } st_e;
endpackage

// File: rtl/i2c_sclt_cfg.sv
module i2c_sclt_cfg #(
  parameter int CFG_W  = 32,
  parameter int CODE_W = 3,
  parameter int LO_LSB = 0,
  parameter int HI_LSB = 4,
  parameter int CNT_W  = CODE_W + 1,
  parameter logic [CFG_W-1:0] RST_VAL = 32'h77
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [CNT_W-1:0] lo_len,
  output logic [CNT_W-1:0] hi_len
);
  localparam logic [CFG_W-1:0] CODE_ONES = CFG_W'((1 << CODE_W) - 1);
  localparam logic [CFG_W-1:0] FIELD_MASK = (CODE_ONES << LO_LSB) | (CODE_ONES << HI_LSB);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= RST_VAL & FIELD_MASK;
    else if (cfg_we) cfg_q <= cfg_wdata & FIELD_MASK;
  end

  assign cfg_rdata = cfg_q;
  assign lo_len = CNT_W'(cfg_q[LO_LSB +: CODE_W]) + CNT_W'(2);
  assign hi_len = CNT_W'(cfg_q[HI_LSB +: CODE_W]) + CNT_W'(2);

  // R1
  cfg_wr_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & FIELD_MASK)));
endmodule

// File: rtl/i2c_sclt_sync.sv
module i2c_sclt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr[0] <= 1'b1;
          else sr[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr[g] <= 1'b1;
          else sr[g] <= sr[g-1];
        end
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/i2c_sclt_cnt.sv
module i2c_sclt_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      len_q <= CNT_W'(2);
    end else if (start) begin
      cnt   <= '0;
      len_q <= len;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign last = tick && (cnt == (len_q - CNT_W'(1)));
endmodule

// File: rtl/i2c_sclt_fsm.sv
module i2c_sclt_fsm
  import i2c_scl_timing_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_bit,
  input  logic             scl_s,
  input  logic             cnt_last,
  input  logic [CNT_W-1:0] lo_len,
  input  logic [CNT_W-1:0] hi_len,
  output logic             cnt_start,
  output logic [CNT_W-1:0] cnt_len,
  output logic             req_ready,
  output logic             phase_done,
  output logic             scl_pull,
  output logic             sda_pull
);
  st_e state;
  op_e op_q;
  logic acc;

  assign req_ready = (state == S_IDLE);
  assign acc = req_valid && req_ready;

  always_comb begin
    cnt_start = 1'b0;
    cnt_len   = lo_len;
    case (state)
      S_IDLE: if (acc) cnt_start = 1'b1;
      S_BUF: if (cnt_last) begin
        cnt_start = 1'b1;
        cnt_len   = hi_len;
      end
      S_WHI: if (scl_s) begin
        cnt_start = 1'b1;
        cnt_len   = (op_q == OP_RSTART) ? lo_len : hi_len;
      end
      S_SU: if (cnt_last && op_q == OP_RSTART) begin
        cnt_start = 1'b1;
        cnt_len   = hi_len;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_START;
      phase_done <= 1'b0;
      scl_pull   <= 1'b0;
      sda_pull   <= 1'b0;
    end else begin
      phase_done <= 1'b0;
      case (state)
        S_IDLE: if (acc) begin
          op_q <= op_e'(req_op);
          if (op_e'(req_op) == OP_START) begin
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
            state    <= S_BUF;
          end else begin
            scl_pull <= 1'b1;
            case (op_e'(req_op))
              OP_RSTART: sda_pull <= 1'b0;
              OP_STOP:   sda_pull <= 1'b1;
              default:   sda_pull <= ~req_bit;
            endcase
            state <= S_LO;
          end
        end
        S_BUF: if (cnt_last) begin
          sda_pull <= 1'b1;
          state    <= S_HOLD;
        end
        S_HOLD: if (cnt_last) begin
          scl_pull   <= 1'b1;
          phase_done <= 1'b1;
          state      <= S_IDLE;
        end
        S_LO: if (cnt_last) begin
          scl_pull <= 1'b0;
          state    <= S_WHI;
        end
        S_WHI: if (scl_s) begin
          state <= (op_q == OP_BIT) ? S_HI : S_SU;
        end
        S_SU: if (cnt_last) begin
          if (op_q == OP_RSTART) begin
            sda_pull <= 1'b1;
            state    <= S_HOLD;
          end else begin
            sda_pull   <= 1'b0;
            phase_done <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_HI: if (cnt_last || !scl_s) begin
          scl_pull   <= 1'b1;
          phase_done <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    phase_done |=> !phase_done);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> $stable(op_q));

  // R4
  stretch_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_WHI && !scl_s) |=> (state == S_WHI && !scl_pull));

  // R5
  high_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_HI && !scl_s) |=> (scl_pull && phase_done));

  // R6
  start_cond_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull) && !scl_pull) |->
      ($past(state) == S_BUF || ($past(state) == S_SU && op_q == OP_RSTART)));
endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing #(
  parameter int CFG_W       = 32,
  parameter int CODE_W      = 3,
  parameter int LO_LSB      = 0,
  parameter int HI_LSB      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [CFG_W-1:0] RST_VAL = 32'h77
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_bit,
  output logic             req_ready,
  output logic             phase_done,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             sda_pull
);
  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] lo_len, hi_len, cnt_len;
  logic scl_s, cnt_start, cnt_last;

  i2c_sclt_cfg #(
    .CFG_W(CFG_W), .CODE_W(CODE_W), .LO_LSB(LO_LSB), .HI_LSB(HI_LSB),
    .CNT_W(CNT_W), .RST_VAL(RST_VAL)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lo_len(lo_len), .hi_len(hi_len)
  );

  i2c_sclt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(scl_in), .dout(scl_s)
  );

  i2c_sclt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .start(cnt_start),
    .len(cnt_len), .last(cnt_last)
  );

  i2c_sclt_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bit(req_bit), .scl_s(scl_s), .cnt_last(cnt_last),
    .lo_len(lo_len), .hi_len(hi_len), .cnt_start(cnt_start),
    .cnt_len(cnt_len), .req_ready(req_ready), .phase_done(phase_done),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );
endmodule

// File: tb/i2c_scl_timing_tb.sv
module i2c_scl_timing_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic req_bit = 1'b0;
  logic req_ready, phase_done, scl_pull, sda_pull;
  logic ext_hold = 1'b0;
  logic scl_line;

  assign scl_line = ~(scl_pull | ext_hold);

  i2c_scl_timing u_dut (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_op(req_op),
    .req_bit(req_bit), .req_ready(req_ready), .phase_done(phase_done),
    .scl_in(scl_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  always #2 clk = ~clk;

  int tick_per = 1;
  int tph = 0;
  always @(negedge clk) begin
    if (tph + 1 >= tick_per) begin tph <= 0; tick <= 1'b1; end
    else begin tph <= tph + 1; tick <= 1'b0; end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int r_done, r_pull1, r_pull0, r_llow, r_lhigh, r_sda1, r_ticks1;
  int r_sda0, r_sda_end, r_scl_end, r_next_done;

  task automatic set_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run_op(input int op, input int bitv, input int ext_until,
                        input int cut_at, input int wcfg_at, input logic [31:0] wcfg_val,
                        input int rq_lo, input int rq_hi);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_bit = bitv[0];
    @(negedge clk);
    req_valid = 1'b0;
    r_done = -1; r_pull1 = 0; r_pull0 = 0; r_llow = 0; r_lhigh = 0;
    r_sda1 = -1; r_ticks1 = 0; r_sda0 = -1; r_sda_end = -1; r_scl_end = -1;
    for (int k = 0; k < 300; k++) begin
      ext_hold = (k < ext_until) || (cut_at >= 0 && k >= cut_at && k < cut_at + 4);
      cfg_we = (k == wcfg_at);
      cfg_wdata = wcfg_val;
      req_valid = (k >= rq_lo && k < rq_hi);
      req_op = 2'd2;
      #1;
      if (k == 0) r_sda0 = int'(sda_pull);
      if (phase_done) begin
        r_done = k; r_sda_end = int'(sda_pull); r_scl_end = int'(scl_pull);
        break;
      end
      if (scl_pull) r_pull1++; else r_pull0++;
      if (scl_line) r_lhigh++; else r_llow++;
      if (tick && scl_pull) r_ticks1++;
      if (sda_pull && r_sda1 < 0) r_sda1 = k;
      @(negedge clk);
    end
    cfg_we = 1'b0; req_valid = 1'b0; ext_hold = 1'b0;
    @(negedge clk); #1;
    r_next_done = int'(phase_done);
  endtask

  function automatic int lenof(input logic [31:0] c, input int lsb);
    return int'((c >> lsb) & 32'h7) + 2;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lo, hi;
    logic [31:0] c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset value, R10 idle state
    chk("R1", "reset cfg", int'(cfg_rdata), 32'h77);
    chk("R10", "reset ready", int'(req_ready), 1);
    chk("R10", "reset done", int'(phase_done), 0);
    chk("R9", "reset scl_pull", int'(scl_pull), 0);
    chk("R9", "reset sda_pull", int'(sda_pull), 0);

    // R1 field placement
    set_cfg(32'hFFFF_FFFF); #1;
    chk("R1", "all ones", int'(cfg_rdata), 32'h77);
    set_cfg(32'hABCD_EF5A); #1;
    chk("R1", "mixed", int'(cfg_rdata), 32'h52);
    set_cfg(32'h0000_0025); #1;
    chk("R1", "plain", int'(cfg_rdata), 32'h25);

    // R6 START
    c = 32'h31; lo = lenof(c, 0); hi = lenof(c, 4);
    set_cfg(c);
    run_op(0, 0, 0, -1, -1, 0, 0, 0);
    chk("R6", "start done idx", r_done, lo + hi);
    chk("R6", "start sda pull idx", r_sda1, lo);
    chk("R6", "start scl released", r_pull0, lo + hi);
    chk("R6", "start scl end", r_scl_end, 1);
    chk("R10", "start done width", r_next_done, 0);

    // R2 R3 R9 R10: sweep of every code pair
    for (int lc = 0; lc < 8; lc++) begin
      for (int hc = 0; hc < 8; hc++) begin
        int b;
        b = (lc + hc) & 1;
        c = 32'(lc) | (32'(hc) << 4);
        set_cfg(c);
        run_op(3, b, 0, -1, -1, 0, 0, 0);
        chk("R2", "bit low len", r_pull1, lc + 2);
        chk("R3", "bit high len", r_pull0, hc + 2 + 3);
        chk("R3", "bit done idx", r_done, lc + hc + 7);
        chk("R9", "bit sda", r_sda0, 1 - b);
        chk("R10", "bit done width", r_next_done, 0);
      end
    end

    // R4 clock stretching
    c = 32'h21; lo = lenof(c, 0); hi = lenof(c, 4);
    set_cfg(c);
    for (int e = 1; e <= 4; e++) begin
      run_op(3, 1, lo + e, -1, -1, 0, 0, 0);
      chk("R4", "stretch low", r_llow, lo + e);
      chk("R4", "stretch high", r_lhigh, hi + 3);
    end

    // R5 high-phase cut, swept across the natural end
    c = 32'h71; lo = lenof(c, 0); hi = lenof(c, 4);
    set_cfg(c);
    for (int j = 0; j < 9; j++) begin
      int m, ex;
      m = lo + 3 + j;
      ex = (m + 3 < lo + 3 + hi) ? m + 3 : lo + 3 + hi;
      run_op(3, 0, 0, m, -1, 0, 0, 0);
      chk("R5", "cut done idx", r_done, ex);
      chk("R5", "cut scl end", r_scl_end, 1);
    end

    // R11 mid-phase configuration write
    set_cfg(32'h11);
    run_op(3, 1, 0, -1, 1, 32'h66, 0, 0);
    chk("R11", "old low len", r_pull1, 3);
    chk("R11", "new high len", r_pull0, 8 + 3);

    // R10 request while busy is ignored
    set_cfg(32'h22);
    run_op(3, 0, 0, -1, -1, 0, 2, 5);
    chk("R10", "busy req done idx", r_done, 4 + 4 + 3);
    for (int q = 0; q < 10; q++) begin
      @(negedge clk); #1;
      chk("R10", "lines held scl", int'(scl_pull), 1);
      chk("R10", "lines held sda", int'(sda_pull), 1);
      chk("R10", "no extra done", int'(phase_done), 0);
    end

    // R12 tick gating
    for (int p = 2; p <= 3; p++) begin
      tick_per = p;
      for (int lc = 0; lc < 8; lc += 3) begin
        set_cfg(32'(lc) | 32'h10);
        run_op(3, 1, 0, -1, -1, 0, 0, 0);
        chk("R12", "ticks in low", r_ticks1, lc + 2);
        chk("R12", "low spans ticks", (r_pull1 >= (lc + 1) * p + 1) ? 1 : 0, 1);
      end
    end
    tick_per = 1;
    repeat (4) @(negedge clk);

    // R7 repeated START
    c = 32'h42; lo = lenof(c, 0); hi = lenof(c, 4);
    set_cfg(c);
    run_op(1, 0, 0, -1, -1, 0, 0, 0);
    chk("R7", "rstart sda start", r_sda0, 0);
    chk("R7", "rstart sda pull idx", r_sda1, 2 * lo + 3);
    chk("R7", "rstart done idx", r_done, 2 * lo + 3 + hi);
    chk("R7", "rstart scl end", r_scl_end, 1);

    // R8 STOP
    c = 32'h13; lo = lenof(c, 0); hi = lenof(c, 4);
    set_cfg(c);
    run_op(2, 0, 0, -1, -1, 0, 0, 0);
    chk("R8", "stop sda held", r_sda0, 1);
    chk("R8", "stop done idx", r_done, lo + 3 + hi);
    chk("R8", "stop sda end", r_sda_end, 0);
    chk("R8", "stop scl end", r_scl_end, 0);

    // R6 START after STOP waits bus-free time
    run_op(0, 0, 0, -1, -1, 0, 0, 0);
    chk("R6", "restart bus free", r_sda1, lo);
    chk("R6", "restart done idx", r_done, lo + hi);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule